// File: doc/BRIEF.md
# Decoder Video Capture Front End

This block sits behind an external standard-definition video decoder and turns its raw output into a framed pixel stream. It takes a 10-bit 4:2:2 luma/chroma word per pixel clock, along with a separate frame sync and line sync. Only the programmed active window of each field is kept. Horizontal and vertical blanking, and anything outside the window, is discarded. The active words are queued in an internal FIFO and leave through a ready/valid port. Each word carries three tags: start of image, end of image, and which field of the interlaced frame it belongs to.

A small register port configures the block before capture. It sets the active level of each sync input, the number of active words per line and the number of active lines per field. It also holds an enable bit and a sticky overflow flag. Capture begins only at the start of a complete frame, which is a first-field boundary, after enable is set. The input side, the FIFO and the output side share one clock.

Top module: `vid_capture_top`

## Requirements
- R1: After reset, `pix_valid` is 0. The control register (address 0) reads 6: enable bit 0 clear, bits 1 and 2 set so both syncs are active high. The word count (address 1) reads 720, the line count (address 2) reads 288 and status (address 3) reads 0.
- R2: Lines start counting from 0 when the frame sync goes inactive. A line is one stretch where line sync is inactive, and its words are numbered from 0. A word is captured only when the frame sync is inactive, the word number is below the programmed word count and the line number is below the programmed line count. Captured words leave in arrival order.
- R3: Control bit 1 sets the active level of the frame sync and control bit 2 sets the active level of the line sync. In each case 1 means active high and 0 means active low.
- R4: `pix_soi` is 1 only on word 0 of line 0 of the first field. `pix_eoi` is 1 only on the last word of the last line of the second field.
- R5: At the frame sync's leading edge, the block samples the line sync. If the line sync is active, the field is the first (`pix_field` = 0). Otherwise it is the second (`pix_field` = 1). The tag holds for that whole field.
- R6: Capture is armed only at a first-field leading edge that occurs while enable (control bit 0) is set. Any field that arrives before this produces no output. Clearing enable stops capture at once.
- R7: While `pix_valid` is 1 and `pix_ready` is 0, the output word and its tags stay unchanged. No word is lost or repeated.
- R8: If a word should be captured while the FIFO is full, status bit 0 is set. That word and the rest of its line are dropped. Words already queued are kept. The bit stays set until a write to address 3 with bit 0 set.
- R9: Registers at addresses 0 to 2 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data (combinational on address) |
| vid_data | input | 10 | Decoder pixel word |
| vid_fsync | input | 1 | Frame sync from decoder |
| vid_lsync | input | 1 | Line sync from decoder |
| pix_ready | input | 1 | Downstream ready |
| pix_valid | output | 1 | Output word valid |
| pix_data | output | 10 | Output pixel word |
| pix_soi | output | 1 | First word of a frame |
| pix_eoi | output | 1 | Last word of a frame |
| pix_field | output | 1 | Field tag, 0 first, 1 second |

## Verification
A wrong line or word counter shows up one output word later. The extra, missing or shifted word appears right after the line boundary concerned, and the start and end tags move with it. If the field latch or the arming state is wrong, the first field's words come out with the wrong tag, or a frame is captured that should have been skipped. That error is visible before the first field ends. FIFO pointer or count errors appear under backpressure and at overflow: duplicated or lost words, a missing error flag, or a number of retained words other than the FIFO depth.

// File: rtl/vdc_pkg.sv
package vdc_pkg;

    localparam int PIX_W = 10;

    typedef struct packed {
        logic             field;
        logic             eoi;
        logic             soi;
        logic [PIX_W-1:0] data;
    } pix_word_t;

    localparam int WORD_W = $bits(pix_word_t);

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_PIX   = 2'd1,
        ADDR_LINES = 2'd2,
        ADDR_STAT  = 2'd3
    } reg_addr_e;

    function automatic logic sync_active(input logic level, input logic pol_high);
        return level == pol_high;
    endfunction

endpackage

// File: rtl/vdc_regs.sv
module vdc_regs #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             ovf_evt,
    output logic             cap_en,
    output logic             fs_pol,
    output logic             ls_pol,
    output logic [CNT_W-1:0] act_pix,
    output logic [CNT_W-1:0] act_lines,
    output logic             err_flag
);
    import vdc_pkg::*;

    localparam logic [CNT_W-1:0] PIX_RST   = CNT_W'(720);
    localparam logic [CNT_W-1:0] LINES_RST = CNT_W'(288);

    reg_addr_e addr;
    logic      clr_err;

    assign addr    = reg_addr_e'(reg_addr);
    assign clr_err = reg_wr && (addr == ADDR_STAT) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_en    <= 1'b0;
            fs_pol    <= 1'b1;
            ls_pol    <= 1'b1;
            act_pix   <= PIX_RST;
            act_lines <= LINES_RST;
        end else if (reg_wr) begin
            case (addr)
                ADDR_CTRL: begin
                    cap_en <= reg_wdata[0];
                    fs_pol <= reg_wdata[1];
                    ls_pol <= reg_wdata[2];
                end
                ADDR_PIX:   act_pix   <= reg_wdata;
                ADDR_LINES: act_lines <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            err_flag <= 1'b0;
        else if (ovf_evt)
            err_flag <= 1'b1;
        else if (clr_err)
            err_flag <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        case (addr)
            ADDR_CTRL:  reg_rdata[2:0] = {ls_pol, fs_pol, cap_en};
            ADDR_PIX:   reg_rdata = act_pix;
            ADDR_LINES: reg_rdata = act_lines;
            ADDR_STAT:  reg_rdata[0] = err_flag;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/vdc_capture.sv
module vdc_capture #(
    parameter int CNT_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cap_en,
    input  logic                     fs_pol,
    input  logic                     ls_pol,
    input  logic [CNT_W-1:0]         act_pix,
    input  logic [CNT_W-1:0]         act_lines,
    input  logic [vdc_pkg::PIX_W-1:0] vid_data,
    input  logic                     vid_fsync,
    input  logic                     vid_lsync,
    input  logic                     fifo_full,
    output logic                     fifo_wr,
    output vdc_pkg::pix_word_t       fifo_word,
    output logic                     ovf_evt
);
    import vdc_pkg::*;

    logic             fs_act, ls_act, fs_d, ls_d;
    logic             fs_lead, ls_rise;
    logic             armed, field_q, drop_line;
    logic [CNT_W-1:0] line_cnt, word_cnt;
    logic             in_win;

    assign fs_act  = sync_active(vid_fsync, fs_pol);
    assign ls_act  = sync_active(vid_lsync, ls_pol);
    assign fs_lead = fs_act && !fs_d;
    assign ls_rise = ls_act && !ls_d;

    // a word inside the programmed window of an armed frame
    assign in_win = cap_en && armed && !fs_act && !ls_act &&
                    (word_cnt < act_pix) && (line_cnt < act_lines);

    assign fifo_wr = in_win && !fifo_full && !drop_line;
    assign ovf_evt = in_win && fifo_full && !drop_line;

    always_comb begin
        fifo_word.data  = vid_data;
        fifo_word.field = field_q;
        fifo_word.soi   = !field_q && (line_cnt == '0) && (word_cnt == '0);
        fifo_word.eoi   = field_q && (line_cnt == act_lines - CNT_W'(1)) &&
                          (word_cnt == act_pix - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_d      <= 1'b1;
            ls_d      <= 1'b1;
            armed     <= 1'b0;
            field_q   <= 1'b0;
            line_cnt  <= '0;
            word_cnt  <= '0;
            drop_line <= 1'b0;
        end else begin
            fs_d <= fs_act;
            ls_d <= ls_act;

            if (!cap_en)
                armed <= 1'b0;
            else if (fs_lead && ls_act)
                armed <= 1'b1;

            if (fs_lead)
                field_q <= !ls_act;

            if (fs_act)
                line_cnt <= '0;
            else if (ls_rise && line_cnt != '1)
                line_cnt <= line_cnt + CNT_W'(1);

            if (ls_act)
                word_cnt <= '0;
            else if (word_cnt != '1)
                word_cnt <= word_cnt + CNT_W'(1);

            if (ls_act)
                drop_line <= 1'b0;
            else if (ovf_evt)
                drop_line <= 1'b1;
        end
    end

endmodule

// File: rtl/vdc_fifo.sv
module vdc_fifo #(
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  vdc_pkg::pix_word_t wr_word,
    input  logic               rd,
    output vdc_pkg::pix_word_t rd_word,
    output logic               empty,
    output logic               full
);
    import vdc_pkg::*;

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    pix_word_t        mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             do_wr, do_rd;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_wr   = wr && !full;
    assign do_rd   = rd && !empty;
    assign rd_word = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr)
                wptr <= (wptr == LAST) ? '0 : wptr + PTR_W'(1);
            if (do_rd)
                rptr <= (rptr == LAST) ? '0 : rptr + PTR_W'(1);
            case ({do_wr, do_rd})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/vid_capture_top.sv
module vid_capture_top #(
    parameter int CNT_W      = 12,
    parameter int FIFO_DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic [9:0]       vid_data,
    input  logic             vid_fsync,
    input  logic             vid_lsync,
    input  logic             pix_ready,
    output logic             pix_valid,
    output logic [9:0]       pix_data,
    output logic             pix_soi,
    output logic             pix_eoi,
    output logic             pix_field
);
    import vdc_pkg::*;

    logic             cap_en, fs_pol, ls_pol, err_flag, ovf_evt;
    logic [CNT_W-1:0] act_pix, act_lines;
    logic             fifo_wr, fifo_full, fifo_empty;
    pix_word_t        wr_word, head;

    vdc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ovf_evt   (ovf_evt),
        .cap_en    (cap_en),
        .fs_pol    (fs_pol),
        .ls_pol    (ls_pol),
        .act_pix   (act_pix),
        .act_lines (act_lines),
        .err_flag  (err_flag)
    );

    vdc_capture #(.CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .fs_pol    (fs_pol),
        .ls_pol    (ls_pol),
        .act_pix   (act_pix),
        .act_lines (act_lines),
        .vid_data  (vid_data),
        .vid_fsync (vid_fsync),
        .vid_lsync (vid_lsync),
        .fifo_full (fifo_full),
        .fifo_wr   (fifo_wr),
        .fifo_word (wr_word),
        .ovf_evt   (ovf_evt)
    );

    vdc_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr      (fifo_wr),
        .wr_word (wr_word),
        .rd      (pix_ready),
        .rd_word (head),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    assign pix_valid = !fifo_empty;
    assign pix_data  = head.data;
    assign pix_soi   = head.soi;
    assign pix_eoi   = head.eoi;
    assign pix_field = head.field;

endmodule

// File: rtl/vdc_checker.sv
module vdc_checker (
    input logic       clk,
    input logic       rst,
    input logic       pix_valid,
    input logic       pix_ready,
    input logic [9:0] pix_data,
    input logic       pix_soi,
    input logic       pix_eoi,
    input logic       pix_field,
    input logic       fifo_wr,
    input logic       fifo_full,
    input logic       cap_en,
    input logic       err_flag,
    input logic       clr_req
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !pix_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        pix_valid && !pix_ready |=> pix_valid && $stable(pix_data) &&
        $stable(pix_soi) && $stable(pix_eoi) && $stable(pix_field));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        !(fifo_wr && fifo_full));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err_flag && !clr_req |=> err_flag);

    assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> cap_en);

    assert_marks_R4: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> !(pix_soi && pix_eoi));

endmodule

bind vid_capture_top vdc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_data  (pix_data),
    .pix_soi   (pix_soi),
    .pix_eoi   (pix_eoi),
    .pix_field (pix_field),
    .fifo_wr   (fifo_wr),
    .fifo_full (fifo_full),
    .cap_en    (cap_en),
    .err_flag  (err_flag),
    .clr_req   (reg_wr && (reg_addr == 2'd3) && reg_wdata[0])
);

// File: tb/test_vid_capture_top.sv
`timescale 1ns/1ps
module test_vid_capture_top;

    localparam int CNT_W = 12;
    localparam int DEPTH = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [CNT_W-1:0] reg_wdata = '0;
    logic [CNT_W-1:0] reg_rdata;
    logic [9:0]       vid_data = '0;
    logic             vid_fsync = 1'b0;
    logic             vid_lsync = 1'b1;
    logic             pix_ready = 1'b0;
    logic             pix_valid;
    logic [9:0]       pix_data;
    logic             pix_soi, pix_eoi, pix_field;

    int n_checks = 0;
    int n_fail   = 0;
    int rmode    = 0;
    logic tb_fs_pol = 1'b1;
    logic tb_ls_pol = 1'b1;

    logic [9:0] cap_d [512];
    logic       cap_s [512];
    logic       cap_e [512];
    logic       cap_f [512];
    int         cap_n = 0;

    always #5 clk = ~clk;

    vid_capture_top #(.CNT_W(CNT_W), .FIFO_DEPTH(DEPTH)) i_vid_capture_top (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vid_data(vid_data),
        .vid_fsync(vid_fsync), .vid_lsync(vid_lsync), .pix_ready(pix_ready),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_soi(pix_soi),
        .pix_eoi(pix_eoi), .pix_field(pix_field)
    );

    // ready pattern and output capture, both away from the rising edge
    always @(negedge clk) begin
        case (rmode)
            0: pix_ready = 1'b1;
            1: pix_ready = ~pix_ready;
            default: pix_ready = 1'b0;
        endcase
        if (pix_valid && pix_ready && cap_n < 512) begin
            cap_d[cap_n] = pix_data;
            cap_s[cap_n] = pix_soi;
            cap_e[cap_n] = pix_eoi;
            cap_f[cap_n] = pix_field;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FIFO FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [CNT_W-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_sync(input bit fs, input bit ls);
        vid_fsync = fs ? tb_fs_pol : ~tb_fs_pol;
        vid_lsync = ls ? tb_ls_pol : ~tb_ls_pol;
    endtask

    // one field: leading edge, blank lines, then nlines lines of npix words
    task automatic send_field(input bit fld, input int nlines, input int npix, input int base);
        set_sync(0, 1); tick(2);
        if (fld) begin
            set_sync(0, 0); tick(2);
            set_sync(1, 0); tick(2);
            set_sync(1, 1); tick(2);
        end else begin
            set_sync(1, 1); tick(4);
        end
        repeat (2) begin
            set_sync(1, 0); tick(3);
            set_sync(1, 1); tick(2);
        end
        set_sync(0, 1); tick(2);
        for (int l = 0; l < nlines; l++) begin
            for (int i = 0; i < npix; i++) begin
                set_sync(0, 0);
                vid_data = 10'(base + l * 16 + i);
                tick(1);
            end
            set_sync(0, 1); tick(3);
        end
        tick(2);
    endtask

    // checks a full captured frame of 2 fields x lines x pix
    task automatic check_frame(input int lines, input int pix, input int b0, input int b1, input string req);
        int per = lines * pix;
        check(cap_n == 2 * per, {req, " word count"}, cap_n, 2 * per);
        for (int k = 0; k < 2 * per && k < cap_n; k++) begin
            int f = k / per;
            int l = (k % per) / pix;
            int i = k % pix;
            int exp_d = ((f == 0) ? b0 : b1) + l * 16 + i;
            check(cap_d[k] == 10'(exp_d), {req, " R2 data"}, int'(cap_d[k]), exp_d);
            check(cap_f[k] == f[0], "R5 field tag", int'(cap_f[k]), f);
            check(cap_s[k] == (k == 0), "R4 soi", int'(cap_s[k]), int'(k == 0));
            check(cap_e[k] == (k == 2 * per - 1), "R4 eoi", int'(cap_e[k]), int'(k == 2 * per - 1));
        end
    endtask

    task automatic test_reset;
        logic [CNT_W-1:0] d;
        check(pix_valid == 1'b0, "R1 valid after reset", int'(pix_valid), 0);
        reg_read(2'd0, d); check(d == 6,   "R1 ctrl reset",  int'(d), 6);
        reg_read(2'd1, d); check(d == 720, "R1 words reset", int'(d), 720);
        reg_read(2'd2, d); check(d == 288, "R1 lines reset", int'(d), 288);
        reg_read(2'd3, d); check(d == 0,   "R1 status reset", int'(d), 0);
    endtask

    task automatic test_regs;
        logic [CNT_W-1:0] d;
        reg_write(2'd1, 12'd5);  reg_read(2'd1, d); check(d == 5,  "R9 words readback", int'(d), 5);
        reg_write(2'd2, 12'd33); reg_read(2'd2, d); check(d == 33, "R9 lines readback", int'(d), 33);
        reg_write(2'd0, 12'd2);  reg_read(2'd0, d); check(d == 2,  "R9 ctrl readback", int'(d), 2);
        reg_write(2'd0, 12'd6);
    endtask

    task automatic test_frame;
        rmode = 0;
        reg_write(2'd1, 12'd4);
        reg_write(2'd2, 12'd2);
        reg_write(2'd0, 12'd7);
        cap_n = 0;
        send_field(1'b1, 3, 6, 'h300);
        tick(10);
        check(cap_n == 0, "R6 second field before arming", cap_n, 0);
        send_field(1'b0, 3, 6, 'h100);
        send_field(1'b1, 3, 6, 'h200);
        tick(20);
        check_frame(2, 4, 'h100, 'h200, "R2");
    endtask

    task automatic test_polarity;
        rmode = 0;
        reg_write(2'd0, 12'd0);
        tb_fs_pol = 1'b0; tb_ls_pol = 1'b0;
        set_sync(0, 1); tick(3);
        reg_write(2'd0, 12'd1);
        cap_n = 0;
        send_field(1'b0, 2, 4, 'h040);
        send_field(1'b1, 2, 4, 'h080);
        tick(20);
        check(cap_n == 16, "R3 active-low word count", cap_n, 16);
        check(cap_d[0] == 10'h040, "R3 first word", int'(cap_d[0]), 'h40);
        check(cap_e[15] == 1'b1, "R3 eoi on last", int'(cap_e[15]), 1);
        reg_write(2'd0, 12'd6);
        tb_fs_pol = 1'b1; tb_ls_pol = 1'b1;
        set_sync(0, 1); tick(3);
    endtask

    task automatic test_backpressure;
        reg_write(2'd0, 12'd7);
        rmode = 1;
        cap_n = 0;
        send_field(1'b0, 2, 4, 'h150);
        send_field(1'b1, 2, 4, 'h250);
        tick(40);
        check_frame(2, 4, 'h150, 'h250, "R7");
        rmode = 0;
    endtask

    task automatic test_overflow;
        logic [CNT_W-1:0] d;
        reg_write(2'd1, 12'd6);
        reg_write(2'd2, 12'd4);
        rmode = 2;
        tick(2);
        cap_n = 0;
        send_field(1'b0, 4, 6, 'h100);
        reg_read(2'd3, d); check(d == 1, "R8 error set", int'(d), 1);
        rmode = 0;
        tick(40);
        check(cap_n == DEPTH, "R8 retained words", cap_n, DEPTH);
        check(cap_d[11] == 10'h115, "R8 second line kept", int'(cap_d[11]), 'h115);
        check(cap_d[15] == 10'h123, "R8 partial line head", int'(cap_d[15]), 'h123);
        reg_read(2'd3, d); check(d == 1, "R8 error sticky", int'(d), 1);
        reg_write(2'd3, 12'd1);
        reg_read(2'd3, d); check(d == 0, "R8 error cleared", int'(d), 0);
    endtask

    task automatic test_disable;
        rmode = 0;
        reg_write(2'd0, 12'd6);
        cap_n = 0;
        send_field(1'b0, 2, 4, 'h100);
        send_field(1'b1, 2, 4, 'h200);
        tick(20);
        check(cap_n == 0, "R6 disabled capture", cap_n, 0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("Watchdog FAIL timeout: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        test_reset;
        test_regs;
        test_frame;
        test_polarity;
        test_backpressure;
        test_overflow;
        test_disable;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule